// File: doc/BRIEF.md
# Timeslot-16 Clear Channel Port

This block carries a transparent 64 kbit/s clear channel through timeslot 16 of a 32-channel, 8-bit-per-channel E1 frame. On the transmit side it makes a 64 kHz sampling clock from the system frame timebase. It shifts in eight serial bits per frame from a dedicated input and hands the finished octet to the framer for timeslot 16 of the next frame. On the receive side it takes the eight timeslot-16 bits from the received line stream and plays them out, one frame later, on a dedicated serial output. A second 64 kHz clock, derived from the receive timebase, goes with that output.

Each timebase is given as a per-bit-time strobe plus a frame pulse that marks bit 0 of channel 0. Both 64 kHz clocks change level only at the start of an even channel and rise at the start of channels 2, 6, 10 and so on up to 30. That gives eight rising edges per frame. When the clear channel is disabled, the transmit octet falls back to an idle pattern and the serial output rests at one. Signalling multiframe handling is not part of this block.

Top module: `ts16_clear_port`

## Requirements
- R1: After reset, `tx_slot_octet` equals the idle octet (default 8'hFF), `cc_rx_out` is 1, and both 64 kHz clocks are 0.
- R2: After any system bit time in channel c, `cc_tx_clk` equals bit 1 of c, so it is 1 for c mod 4 in {2,3}. It changes only on the bit-0 strobe of an even channel. It rises at channels 2, 6, ..., 30 and falls at channels 0, 4, ..., 28.
- R3: `cc_tx_in` is sampled only at bit 0 of channels 2, 6, ..., 30, which are the bit times where `cc_tx_clk` rises. The sample at channel 2 becomes octet bit 7 and the sample at channel 2+4k becomes bit 7-k.
- R4: At each system frame start with `cc_enable` high, `tx_slot_octet` takes the octet gathered during the previous frame. `tx_slot_octet` changes at no other time.
- R5: `cc_rx_clk` follows the rule of R2, but counts channels from the receive frame pulse and strobe. It is independent of the system timebase.
- R6: The received octet is formed from the 8 `rx_line_bit` values of receive channel 16, bits 0..7. Bit 0 of the channel is the MSB.
- R7: The octet received in frame N is presented on `cc_rx_out` during frame N+1. Bit 7-k is driven from the falling edge at channel 4k, on the clock after that strobe, and is held until the next falling edge.
- R8: While `cc_enable` is low, `cc_rx_out` is 1 from the next clock on. A frame start seen with `cc_enable` low loads the idle octet into `tx_slot_octet`.
- R9: Without a strobe, neither timebase advances. A frame pulse given with a strobe restarts the bit position at channel 0, bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cc_enable | input | 1 | Clear channel enable |
| sys_tick | input | 1 | System bit-time strobe (one per 2.048 Mb/s bit) |
| sys_fp | input | 1 | System frame pulse, marks channel 0 bit 0 when sys_tick is high |
| cc_tx_in | input | 1 | Serial 64 kbit/s clear channel data toward the line |
| cc_tx_clk | output | 1 | Internal 64 kHz transmit sampling clock |
| tx_slot_octet | output | 8 | Octet for timeslot 16 of the current transmit frame |
| rx_tick | input | 1 | Receive bit-time strobe from the recovered clock |
| rx_fp | input | 1 | Receive frame pulse, marks channel 0 bit 0 when rx_tick is high |
| rx_line_bit | input | 1 | Received line data, one bit per rx_tick |
| cc_rx_out | output | 1 | Serial 64 kbit/s clear channel data from the line |
| cc_rx_clk | output | 1 | 64 kHz receive clock aligned with cc_rx_out |

## Verification
The assertions check on every cycle that the 64 kHz clocks move only after an edge event and that no timebase position moves without a strobe. They also check that the transmit octet changes only at a frame start, and that the serial output changes only at a falling edge or on disable and is high whenever the port is disabled. The bench scenarios are needed to show the rest. These are the exact clock phase in every channel, which input bit time lands in which octet position, and the one-frame latency on both paths. They also cover the receive timebase running at an offset from the system one, and the idle octet and resting output around enable changes.

// File: rtl/ts16_cc_pkg.sv
// Shared types for the timeslot-16 clear channel port.
// Assumes: both timebases report at most one 64 kHz edge event per bit time.
package ts16_cc_pkg;

    // Edge event of a 64 kHz clock in the current bit time.
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10
    } edge_e;

endpackage

// File: rtl/ts16_timebase.sv
// Frame position counter and 64 kHz clock for one timebase.
// It tracks the bit position inside a frame from a bit strobe and a frame pulse.
// It reports the current channel, edge events and timeslot flags, and drives a
// registered 64 kHz clock that changes at every second channel boundary.
// Assumes: CHANNELS and CH_BITS are powers of two and CHANNELS is a multiple of 4.
module ts16_timebase #(
    parameter int CHANNELS = 32,
    parameter int CH_BITS  = 8,
    parameter int SLOT     = 16,
    parameter int RISE_CH  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  fp,
    output ts16_cc_pkg::edge_e    edge_ev,
    output logic                  frame_start,
    output logic                  in_slot,
    output logic                  slot_last,
    output logic                  clk64
);
    import ts16_cc_pkg::*;

    localparam int FRAME_BITS = CHANNELS * CH_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int BIT_W      = $clog2(CH_BITS);
    localparam int CH_W       = POS_W - BIT_W;
    localparam int LAST_POS   = FRAME_BITS - 1;

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] cur_pos;
    logic [CH_W-1:0]  ch;
    logic [BIT_W-1:0] bitn;
    logic [CH_W-1:0]  ch_rel;
    logic             boundary;
    logic             phase;
    logic             clk64_q;

    // Position of the bit time presented now; a frame pulse forces position 0.
    always_comb begin
        cur_pos  = fp ? '0 : pos_q;
        ch       = cur_pos[POS_W-1:BIT_W];
        bitn     = cur_pos[BIT_W-1:0];
        ch_rel   = ch - CH_W'(RISE_CH);
        phase    = |(ch_rel & CH_W'(2));
        boundary = (bitn == '0) && !ch[0];
    end

    // Edge events and slot flags for the current strobed bit time.
    always_comb begin
        edge_ev     = EDGE_NONE;
        if (tick && boundary) begin
            edge_ev = phase ? EDGE_FALL : EDGE_RISE;
        end
        frame_start = tick && (cur_pos == '0);
        in_slot     = tick && (ch == CH_W'(SLOT));
        slot_last   = in_slot && (bitn == BIT_W'(CH_BITS - 1));
    end

    // Advance the position once per strobe, wrapping at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (tick) begin
            pos_q <= (cur_pos == POS_W'(LAST_POS)) ? '0 : cur_pos + POS_W'(1);
        end
    end

    // Registered 64 kHz clock that follows the edge events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk64_q <= 1'b0;
        end else if (edge_ev == EDGE_RISE) begin
            clk64_q <= 1'b1;
        end else if (edge_ev == EDGE_FALL) begin
            clk64_q <= 1'b0;
        end
    end

    assign clk64 = clk64_q;

    // R9: the position is frozen while no strobe arrives.
    a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pos_q));

    // R2/R5: the clock moves only on the cycle after a boundary strobe.
    a_r2_clk_moves_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk64_q) |-> $past(tick && boundary));

    // R2/R5: a rising event always leaves the clock high.
    a_r5_rise_sets_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_ev == EDGE_RISE) |=> clk64_q);

endmodule

// File: rtl/ts16_tx_gather.sv
// Transmit side: gathers clear channel input bits on 64 kHz rising events.
// At each frame start it publishes the octet gathered during the previous frame,
// or the idle octet when the channel is disabled.
// Assumes: there are exactly CH_BITS rising events per frame.
module ts16_tx_gather #(
    parameter int          CH_BITS = 8,
    parameter logic [7:0]  IDLE    = 8'hFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ts16_cc_pkg::edge_e   edge_ev,
    input  logic                 frame_start,
    input  logic                 enable,
    input  logic                 din,
    output logic [CH_BITS-1:0]   octet
);
    import ts16_cc_pkg::*;

    logic [CH_BITS-1:0] gather_q;
    logic [CH_BITS-1:0] octet_q;

    // Shift one input bit in, MSB first, at every rising event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gather_q <= '0;
        end else if (edge_ev == EDGE_RISE) begin
            gather_q <= {gather_q[CH_BITS-2:0], din};
        end
    end

    // Publish the gathered octet, or the idle octet, at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            octet_q <= CH_BITS'(IDLE);
        end else if (frame_start) begin
            octet_q <= enable ? gather_q : CH_BITS'(IDLE);
        end
    end

    assign octet = octet_q;

    // R4: the published octet changes only right after a frame start.
    a_r4_octet_frame_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(octet_q) |-> $past(frame_start));

    // R8: a disabled frame start yields the idle octet.
    a_r8_idle_octet: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !enable) |=> (octet_q == CH_BITS'(IDLE)));

endmodule

// File: rtl/ts16_rx_spool.sv
// Receive side: captures the timeslot-16 bits from the line stream and
// plays the octet out serially, one bit per 64 kHz falling event, starting
// at the next frame start. The output rests at one while disabled.
// Assumes: the frame start bit time is also a falling event.
module ts16_rx_spool #(
    parameter int CH_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ts16_cc_pkg::edge_e   edge_ev,
    input  logic                 frame_start,
    input  logic                 in_slot,
    input  logic                 slot_last,
    input  logic                 enable,
    input  logic                 line_bit,
    output logic                 dout
);
    import ts16_cc_pkg::*;

    logic [CH_BITS-1:0] cap_q;
    logic [CH_BITS-1:0] hold_q;
    logic [CH_BITS-1:0] play_q;
    logic               dout_q;

    // Shift the timeslot bits in as they arrive, first bit highest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (in_slot) begin
            cap_q <= {cap_q[CH_BITS-2:0], line_bit};
        end
    end

    // Hold the completed octet until the next frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '1;
        end else if (slot_last) begin
            hold_q <= {cap_q[CH_BITS-2:0], line_bit};
        end
    end

    // Play-out shift register advancing on falling events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            play_q <= '1;
        end else if (edge_ev == EDGE_FALL) begin
            play_q <= frame_start ? {hold_q[CH_BITS-2:0], 1'b1}
                                  : {play_q[CH_BITS-2:0], 1'b1};
        end
    end

    // Serial output: forced high when disabled, else the next bit per fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= 1'b1;
        end else if (!enable) begin
            dout_q <= 1'b1;
        end else if (edge_ev == EDGE_FALL) begin
            dout_q <= frame_start ? hold_q[CH_BITS-1] : play_q[CH_BITS-1];
        end
    end

    assign dout = dout_q;

    // R8: disabled output rests at one from the next clock.
    a_r8_rest_high: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> dout_q);

    // R7: the output moves only after a falling event or a disable.
    a_r7_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout_q) |-> $past((edge_ev == EDGE_FALL) || !enable));

endmodule

// File: rtl/ts16_clear_port.sv
// Timeslot-16 clear channel port: a transmit gatherer on the system timebase
// and a receive spooler on the recovered receive timebase. Each has its own
// 64 kHz clock that rises at the start of channel RISE_CH.
// Assumes: CHANNELS / 4 == CH_BITS, so one octet is moved per frame.
module ts16_clear_port #(
    parameter int          CHANNELS = 32,
    parameter int          CH_BITS  = 8,
    parameter int          SLOT     = 16,
    parameter int          RISE_CH  = 2,
    parameter logic [7:0]  IDLE     = 8'hFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cc_enable,
    input  logic                sys_tick,
    input  logic                sys_fp,
    input  logic                cc_tx_in,
    output logic                cc_tx_clk,
    output logic [CH_BITS-1:0]  tx_slot_octet,
    input  logic                rx_tick,
    input  logic                rx_fp,
    input  logic                rx_line_bit,
    output logic                cc_rx_out,
    output logic                cc_rx_clk
);
    import ts16_cc_pkg::*;

    edge_e tx_edge;
    logic  tx_frame_start;
    logic  tx_in_slot;
    logic  tx_slot_last;
    edge_e rx_edge;
    logic  rx_frame_start;
    logic  rx_in_slot;
    logic  rx_slot_last;

    ts16_timebase #(
        .CHANNELS(CHANNELS), .CH_BITS(CH_BITS), .SLOT(SLOT), .RISE_CH(RISE_CH)
    ) u_tx_tb (
        .clk(clk), .rst_n(rst_n), .tick(sys_tick), .fp(sys_fp),
        .edge_ev(tx_edge), .frame_start(tx_frame_start),
        .in_slot(tx_in_slot), .slot_last(tx_slot_last), .clk64(cc_tx_clk)
    );

    ts16_tx_gather #(.CH_BITS(CH_BITS), .IDLE(IDLE)) u_tx (
        .clk(clk), .rst_n(rst_n), .edge_ev(tx_edge), .frame_start(tx_frame_start),
        .enable(cc_enable), .din(cc_tx_in), .octet(tx_slot_octet)
    );

    ts16_timebase #(
        .CHANNELS(CHANNELS), .CH_BITS(CH_BITS), .SLOT(SLOT), .RISE_CH(RISE_CH)
    ) u_rx_tb (
        .clk(clk), .rst_n(rst_n), .tick(rx_tick), .fp(rx_fp),
        .edge_ev(rx_edge), .frame_start(rx_frame_start),
        .in_slot(rx_in_slot), .slot_last(rx_slot_last), .clk64(cc_rx_clk)
    );

    ts16_rx_spool #(.CH_BITS(CH_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .edge_ev(rx_edge), .frame_start(rx_frame_start),
        .in_slot(rx_in_slot), .slot_last(rx_slot_last), .enable(cc_enable),
        .line_bit(rx_line_bit), .dout(cc_rx_out)
    );

    // The transmit slot flags are not needed by the gatherer.
    logic unused_tx_flags;
    assign unused_tx_flags = tx_in_slot ^ tx_slot_last;

    // R1: right after reset the port is idle with both clocks low.
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(!rst_n) |-> (cc_rx_out && !cc_tx_clk && !cc_rx_clk));

endmodule

// File: tb/ts16_clear_port_bench.sv
// Bench: strobes every second clock, 24 frames, receive timebase offset by
// 37 bit times. Expected values come from the requirement arithmetic.
module ts16_clear_port_bench;

    localparam int FRAMES = 24;
    localparam int FBITS  = 256;
    localparam int RX_OFF = 37;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cc_enable = 1'b0;
    logic       sys_tick = 1'b0;
    logic       sys_fp = 1'b0;
    logic       cc_tx_in = 1'b0;
    logic       cc_tx_clk;
    logic [7:0] tx_slot_octet;
    logic       rx_tick = 1'b0;
    logic       rx_fp = 1'b0;
    logic       rx_line_bit = 1'b0;
    logic       cc_rx_out;
    logic       cc_rx_clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ts16_clear_port u_ts16_clear_port (
        .clk(clk), .rst_n(rst_n), .cc_enable(cc_enable),
        .sys_tick(sys_tick), .sys_fp(sys_fp), .cc_tx_in(cc_tx_in),
        .cc_tx_clk(cc_tx_clk), .tx_slot_octet(tx_slot_octet),
        .rx_tick(rx_tick), .rx_fp(rx_fp), .rx_line_bit(rx_line_bit),
        .cc_rx_out(cc_rx_out), .cc_rx_clk(cc_rx_clk)
    );

    function automatic logic [7:0] txd(input int f);
        return 8'((f * 73) ^ 8'h5A);
    endfunction

    function automatic logic [7:0] rxd(input int g);
        return 8'(g * 29 + 8'hC3);
    endfunction

    function automatic logic en(input int f);
        return !(f == 6 || f == 7 || f == 12 || f == 15);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp, input int t);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s tick=%0d actual=%h expected=%h", req, t, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 octet", tx_slot_octet, 8'hFF, -1);
        chk("R1 rx out", {7'd0, cc_rx_out}, 8'd1, -1);
        chk("R1 tx clk", {7'd0, cc_tx_clk}, 8'd0, -1);
        chk("R1 rx clk", {7'd0, cc_rx_clk}, 8'd0, -1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 octet after release", tx_slot_octet, 8'hFF, -1);

        for (int t = 0; t < FRAMES * FBITS; t++) begin
            int f, p, c, b, rt, g, rp, rc, rb;
            f = t / FBITS;  p = t % FBITS;  c = p / 8;  b = p % 8;
            rt = t + RX_OFF;
            g = rt / FBITS; rp = rt % FBITS; rc = rp / 8; rb = rp % 8;

            // Drive one strobed bit time on both timebases.
            cc_enable   = en(f);
            sys_tick    = 1'b1;
            rx_tick     = 1'b1;
            sys_fp      = (p == 0);
            rx_fp       = (rp == 0);
            if (b == 0 && (c % 4) == 2 && c >= 2)
                cc_tx_in = txd(f)[7 - (c - 2) / 4];
            else
                cc_tx_in = ~txd(f)[7 - (((c + 2) / 4) % 8)];
            rx_line_bit = (rc == 16) ? rxd(g)[7 - rb] : (1'(rp) ^ 1'(rp >> 4));
            @(negedge clk);

            // Gap cycle: no strobe; sample the state after bit time t.
            sys_tick = 1'b0;
            rx_tick  = 1'b0;
            sys_fp   = 1'b0;
            rx_fp    = 1'b0;
            cc_tx_in = ~cc_tx_in;
            rx_line_bit = ~rx_line_bit;

            if (f >= 1)
                chk("R2 tx clock phase", {7'd0, cc_tx_clk}, 8'((c / 2) % 2), t);
            if (g >= 1)
                chk("R5 rx clock phase", {7'd0, cc_rx_clk}, 8'((rc / 2) % 2), t);
            if (f >= 2)
                chk(en(f) ? "R3 R4 tx octet" : "R8 idle octet",
                    tx_slot_octet, en(f) ? txd(f - 1) : 8'hFF, t);
            if (!en(f))
                chk("R8 rx rests high", {7'd0, cc_rx_out}, 8'd1, t);
            else if (en(f - 1) && g >= 2)
                chk("R6 R7 rx serial bit", {7'd0, cc_rx_out},
                    {7'd0, rxd(g - 1)[7 - rc / 4]}, t);
            @(negedge clk);
            // R9: one more quiet cycle must not move anything.
            if (f >= 1 && (t % 97) == 0)
                chk("R9 hold without strobe", {7'd0, cc_tx_clk}, 8'((c / 2) % 2), t);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule